// File: doc/BRIEF.md
# GPIO Interrupt Cause Controller

The block watches 32 general-purpose input lines and turns them into four interrupt requests, one per group of eight lines, for an upstream interrupt controller. Each line is first brought into the clock domain by a two-flop synchroniser. It is then optionally inverted by its polarity bit, which gives a per-line "sampled value" word. Two paths read that one word. The level path is gated by a level enable mask and is never latched. The edge path records every 0-to-1 change of the sampled value in a sticky cause register, and an edge enable mask gates what that register passes on.

Because edge detection follows the sampled value and not the raw pin, polarity 0 catches rising pin edges and polarity 1 catches falling ones. Software gets detection on both edges by flipping the polarity bit after each event. A polarity change that turns the sampled value from 0 to 1 counts as an edge. Only lines whose direction bit marks them as inputs can raise a cause.

Registers are reached over a plain 32-bit register bus with an address, a write strobe, write data and read data registered one cycle after the address. The bus is a control port, so it has no valid/ready flow control and never applies back-pressure: every write takes effect at the clock edge that samples it, and a read needs no strobe.

Top module: `gpio_irq_front`

## Requirements
- R1: The sampled-value word is the synchronised pin word XORed with the polarity register (1 = invert), and it can be read at address 0.
- R2: A line's level request is its sampled value ANDed with its level-mask bit, with no latching: it clears as soon as the sampled value falls.
- R3: A 0-to-1 change of a sampled-value bit sets its cause bit, which then holds until it is cleared. With polarity 0 this happens on a pin rise and with polarity 1 on a pin fall. The opposite pin transition sets nothing.
- R4: A set cause bit drives an interrupt only while its edge-mask bit is 1. Clearing the mask bit does not clear the cause bit.
- R5: Group output bit k is the OR of the line requests (level OR masked cause) of lines 8k to 8k+7.
- R6: A polarity write that turns a steady line's sampled value from 0 to 1 sets its cause bit, the same as a pin transition.
- R7: The direction register uses 1 for input. A line with direction 0 produces neither a level request nor a cause bit. Changing a line to an input does not in itself create an edge.
- R8: After reset the level mask, edge mask, cause, polarity and direction registers read 0, and all group outputs are 0.
- R9: Writing the cause register clears each bit written as 0 and keeps each bit written as 1. If an edge occurs in the cycle of a clear, the bit ends up set.
- R10: Writes to the sampled-value address have no effect on any register.
- R11: A pin change reaches the sampled value after 2 clock edges. A group output changes 1 edge after its level request or cause changes, or 1 edge after a mask register is written.
- R12: The address map is: 0 sampled value, 1 polarity, 2 direction, 3 level mask, 4 edge mask, 5 cause. Read data is registered, so it is valid one edge after the address is applied. Addresses 6 and 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | 32 | Asynchronous GPIO line inputs |
| bus_addr_i | input | 3 | Register address |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data for the previous cycle's address |
| grp_irq_o | output | 4 | Registered group interrupt requests, bit k covers lines 8k..8k+7 |

## Verification
Each result has its own delay, counted in clock edges from the stimulus:
- a pin change reaches a level-driven group output 3 edges later;
- a pin change reaches an edge-driven group output 4 edges later;
- a polarity write shows as a set cause bit 1 edge after the write lands, and on the group output 2 edges after it lands;
- a mask write or cause clear reaches the group output 1 edge after it lands;
- read data arrives 1 edge after its address.

The driver records each expectation with the exact cycle it is due in. Where a latency is in question, it also records the unchanged value for the cycle just before. The monitor compares only in the cycle each item names. The same-cycle clear-and-edge case is placed so that the clear write and the cause update share one clock edge.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int REG_ADDR_W = 3;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_DIN       = 3'd0,
    REG_POL       = 3'd1,
    REG_DIR       = 3'd2,
    REG_LVL_MASK  = 3'd3,
    REG_EDGE_MASK = 3'd4,
    REG_CAUSE     = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/gpio_line_sync.sv
module gpio_line_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_latch.sv
module gpio_edge_latch #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din_i,
  input  logic [WIDTH-1:0] enable_i,
  input  logic             clr_we_i,
  input  logic [WIDTH-1:0] keep_i,
  output logic [WIDTH-1:0] cause_o
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] cause_q;
  logic [WIDTH-1:0] evt;
  logic [WIDTH-1:0] clr_mask;

  assign evt      = din_i & ~prev_q & enable_i;
  assign clr_mask = clr_we_i ? ~keep_i : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q  <= '0;
      cause_q <= '0;
    end else begin
      prev_q  <= din_i;
      cause_q <= (cause_q & ~clr_mask) | evt;
    end
  end

  assign cause_o = cause_q;

  assert_cause_rise_needs_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((cause_q & ~$past(cause_q)) & ~$past(evt)) == '0);

  assert_cause_fall_needs_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((~cause_q & $past(cause_q)) & ~$past(clr_mask)) == '0);

  assert_edge_wins_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(evt) & ~cause_q) == '0);
endmodule

// File: rtl/gpio_group_or.sv
module gpio_group_or #(
  parameter int WIDTH      = 32,
  parameter int GROUP_SIZE = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [WIDTH-1:0]              req_i,
  output logic [WIDTH/GROUP_SIZE-1:0]   grp_o
);
  localparam int NUM_GROUPS = WIDTH / GROUP_SIZE;

  logic [NUM_GROUPS-1:0] grp_q;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_group
    always_ff @(posedge clk) begin
      if (!rst_n) grp_q[g] <= 1'b0;
      else        grp_q[g] <= |req_i[g*GROUP_SIZE +: GROUP_SIZE];
    end
  end

  assign grp_o = grp_q;
endmodule

// File: rtl/gpio_irq_front.sv
module gpio_irq_front
  import gpio_irq_pkg::*;
#(
  parameter int NUM_LINES   = 32,
  parameter int GROUP_SIZE  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_LINES-1:0]             pin_i,
  input  logic [REG_ADDR_W-1:0]            bus_addr_i,
  input  logic                             bus_we_i,
  input  logic [NUM_LINES-1:0]             bus_wdata_i,
  output logic [NUM_LINES-1:0]             bus_rdata_o,
  output logic [NUM_LINES/GROUP_SIZE-1:0]  grp_irq_o
);
  localparam int NUM_GROUPS = NUM_LINES / GROUP_SIZE;

  logic [NUM_LINES-1:0] sync_w, din_w, cause_w, req_w;
  logic [NUM_LINES-1:0] pol_q, dir_q, lvl_q, emask_q, rdata_q;
  logic [NUM_GROUPS-1:0] grp_w;
  reg_sel_e             sel;

  assign sel = reg_sel_e'(bus_addr_i);

  gpio_line_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(sync_w));

  assign din_w = sync_w ^ pol_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pol_q   <= '0;
      dir_q   <= '0;
      lvl_q   <= '0;
      emask_q <= '0;
    end else if (bus_we_i) begin
      case (sel)
        REG_POL:       pol_q   <= bus_wdata_i;
        REG_DIR:       dir_q   <= bus_wdata_i;
        REG_LVL_MASK:  lvl_q   <= bus_wdata_i;
        REG_EDGE_MASK: emask_q <= bus_wdata_i;
        default: ;
      endcase
    end
  end

  gpio_edge_latch #(.WIDTH(NUM_LINES)) i_edge (
    .clk(clk), .rst_n(rst_n), .din_i(din_w), .enable_i(dir_q),
    .clr_we_i(bus_we_i && sel == REG_CAUSE), .keep_i(bus_wdata_i),
    .cause_o(cause_w));

  assign req_w = ((din_w & lvl_q) | (cause_w & emask_q)) & dir_q;

  gpio_group_or #(.WIDTH(NUM_LINES), .GROUP_SIZE(GROUP_SIZE)) i_group (
    .clk(clk), .rst_n(rst_n), .req_i(req_w), .grp_o(grp_w));

  assign grp_irq_o = grp_w;

  always_ff @(posedge clk) begin
    if (!rst_n) rdata_q <= '0;
    else begin
      case (sel)
        REG_DIN:       rdata_q <= din_w;
        REG_POL:       rdata_q <= pol_q;
        REG_DIR:       rdata_q <= dir_q;
        REG_LVL_MASK:  rdata_q <= lvl_q;
        REG_EDGE_MASK: rdata_q <= emask_q;
        REG_CAUSE:     rdata_q <= cause_w;
        default:       rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata_o = rdata_q;

  assert_no_irq_when_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lvl_q) == '0 && $past(emask_q) == '0) |-> grp_w == '0);

  assert_no_cause_on_output_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((cause_w & ~$past(cause_w)) & ~$past(dir_q)) == '0);
endmodule

// File: tb/test_gpio_irq_front.sv
module test_gpio_irq_front;
  import gpio_irq_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pin = '0;
  logic [2:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  grp;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    int          due;
    bit          is_rd;
    logic [31:0] exp;
    string       req;
  } item_t;
  item_t sb[$];

  gpio_irq_front i_gpio_irq_front (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .bus_addr_i(addr),
    .bus_we_i(we), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .grp_irq_o(grp));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compare every expectation in the cycle it names
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = sb.size() - 1; i >= 0; i--) begin
        if (sb[i].due == cyc) begin
          logic [31:0] act;
          act = sb[i].is_rd ? rdata : {28'b0, grp};
          checks++;
          if (act !== sb[i].exp) begin
            errors++;
            $display("FAIL %s cycle %0d %s: actual %h expected %h", sb[i].req, cyc,
                     sb[i].is_rd ? "rdata" : "grp", act, sb[i].exp);
          end
          sb.delete(i);
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic push(int lat, bit is_rd, logic [31:0] e, string r);
    item_t it;
    it.due = cyc + lat; it.is_rd = is_rd; it.exp = e; it.req = r;
    sb.push_back(it);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    tick();
    we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, logic [31:0] e, string r);
    addr = a;
    push(1, 1'b1, e, r);
    tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    push(0, 0, 0, "R8");
    rd(REG_LVL_MASK, 0, "R8");
    rd(REG_EDGE_MASK, 0, "R8");
    rd(REG_CAUSE, 0, "R8");
    rd(REG_DIR, 0, "R8");

    // Level path, exact latency
    wr(REG_DIR, 32'hFFFF_FFFF);
    wr(REG_LVL_MASK, 32'h1);
    pin[0] = 1'b1;
    push(2, 0, 0, "R11"); push(3, 0, 1, "R2");
    wait_n(5);
    pin[0] = 1'b0;
    push(2, 0, 1, "R11"); push(3, 0, 0, "R2");
    wait_n(5);

    // Polarity inverts the sampled value
    wr(REG_LVL_MASK, 32'h100);
    wr(REG_POL, 32'h100);
    push(0, 0, 0, "R11"); push(1, 0, 4'b0010, "R1");
    wait_n(2);
    rd(REG_DIN, 32'h100, "R1");
    wr(REG_POL, 0);
    wr(REG_LVL_MASK, 0);
    wr(REG_CAUSE, 0);
    wait_n(2);
    rd(REG_CAUSE, 0, "R9");

    // Rising edge, sticky cause
    wr(REG_EDGE_MASK, 32'h1_0000);
    pin[16] = 1'b1;
    push(3, 0, 0, "R11"); push(4, 0, 4'b0100, "R3");
    wait_n(6);
    pin[16] = 1'b0;
    wait_n(6);
    push(0, 0, 4'b0100, "R3");
    rd(REG_CAUSE, 32'h1_0000, "R3");

    // Edge mask gates, cause persists
    wr(REG_EDGE_MASK, 0);
    push(1, 0, 0, "R4");
    wait_n(2);
    rd(REG_CAUSE, 32'h1_0000, "R4");
    wr(REG_EDGE_MASK, 32'h1_0000);
    push(1, 0, 4'b0100, "R4");
    wait_n(2);

    // Write-one keeps, write-zero clears
    wr(REG_CAUSE, 32'hFFFF_FFFF);
    wait_n(2);
    rd(REG_CAUSE, 32'h1_0000, "R9");
    wr(REG_CAUSE, ~32'h1_0000);
    push(1, 0, 0, "R9");
    wait_n(2);

    // Polarity flip on a steady line counts as an edge
    wr(REG_POL, 32'h1_0000);
    push(1, 0, 0, "R6"); push(2, 0, 4'b0100, "R6");
    wait_n(4);
    wr(REG_CAUSE, 0);
    wait_n(2);
    push(0, 0, 0, "R9");

    // Falling-edge detection with polarity 1
    pin[16] = 1'b1;
    wait_n(6);
    push(0, 0, 0, "R3");
    pin[16] = 1'b0;
    push(3, 0, 0, "R11"); push(4, 0, 4'b0100, "R3");
    wait_n(6);
    wr(REG_CAUSE, 0);
    wr(REG_POL, 0);
    wr(REG_EDGE_MASK, 0);
    wait_n(2);

    // Edge arriving in the cycle of a clear wins
    wr(REG_EDGE_MASK, 32'h2_0000);
    pin[17] = 1'b1;
    wait_n(2);
    wr(REG_CAUSE, 0);
    push(1, 0, 4'b0100, "R9");
    rd(REG_CAUSE, 32'h2_0000, "R9");
    wr(REG_CAUSE, 0);
    wait_n(2);
    push(0, 0, 0, "R9");
    pin[17] = 1'b0;
    wr(REG_EDGE_MASK, 0);
    wait_n(3);

    // Output-direction lines raise nothing
    wr(REG_DIR, ~32'h100_0000);
    wr(REG_LVL_MASK, 32'h100_0000);
    wr(REG_EDGE_MASK, 32'h100_0000);
    pin[24] = 1'b1;
    wait_n(6);
    push(0, 0, 0, "R7");
    rd(REG_CAUSE, 0, "R7");
    wr(REG_DIR, 32'hFFFF_FFFF);
    push(1, 0, 4'b1000, "R7");
    wait_n(2);
    rd(REG_CAUSE, 0, "R7");
    pin[24] = 1'b0;
    push(3, 0, 0, "R2");
    wait_n(4);
    wr(REG_LVL_MASK, 0);
    wr(REG_EDGE_MASK, 0);

    // Grouping
    wr(REG_LVL_MASK, 32'h8000_0000);
    pin[31] = 1'b1;
    push(3, 0, 4'b1000, "R5");
    wait_n(5);
    wr(REG_LVL_MASK, 32'h8000_0080);
    pin[7] = 1'b1;
    push(3, 0, 4'b1001, "R5");
    wait_n(5);
    pin[31] = 1'b0;
    push(3, 0, 4'b0001, "R5");
    wait_n(5);
    pin[7] = 1'b0;
    wr(REG_LVL_MASK, 0);
    wait_n(4);

    // Sampled-value writes ignored; map
    pin[5] = 1'b1;
    wait_n(4);
    wr(REG_DIN, 0);
    rd(REG_DIN, 32'h20, "R10");
    rd(REG_POL, 0, "R10");
    rd(REG_LVL_MASK, 0, "R10");
    rd(REG_DIR, 32'hFFFF_FFFF, "R12");
    rd(3'd6, 0, "R12");
    rd(3'd7, 0, "R12");

    wait_n(4);
    if (sb.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule